// File: doc/BRIEF.md
# Serial Configuration Register Slave

This block is a two-wire serial slave that holds six 8-bit configuration bytes for a clock generator. It runs on a fast system clock and oversamples the bus lines. SCL and SDA each pass through a two-flop synchronizer and then a glitch filter before any edge, start or stop is detected. The slave drives SDA only through an open-drain enable. All six bytes are presented in parallel on `cfg_o`, so the clock logic can use them directly.

The protocol is a fixed block transfer with no register addressing. A write sends the write address, then a command byte and a count byte, and then data. The slave acknowledges the command and count bytes but discards them, and stores the data from byte 0 upward. A read sends the read address. The slave answers with a count byte, then bytes 0 to 5. Three reserved bits of byte 1 are stored as written but return complemented on a read.

Top module: `cfg_i2c_slave`

## Requirements
- R1: The slave acknowledges the 8-bit address 0xD2 as a write and 0xD3 as a read, by holding SDA low during the ninth clock. For any other address SDA stays released in the ninth clock and the transfer is ignored.
- R2: On a write, the two bytes after the address are acknowledged and then discarded. Neither byte changes `cfg_o`.
- R3: Data bytes of a write are stored in arrival order into byte 0, byte 1 and so on. Byte k appears on `cfg_o[8k+7:8k]`.
- R4: Every received byte, whether address or data, is acknowledged in its ninth clock. The slave changes its SDA drive only while the filtered SCL is low.
- R5: A stop after any complete data byte ends the write. Bytes not reached keep their previous values.
- R6: A read returns, MSB first, a count byte of value 6 and then bytes 0 to 5. Every read starts again from the count byte.
- R7: Bits 6, 5 and 4 of byte 1 store the written value on `cfg_o`, but a read returns their complement. All other bits read back unchanged.
- R8: After reset, `cfg_o` equals 48'h06_00_00_FF_FF_FF (byte 5 down to byte 0) and SDA is released.
- R9: A start or stop that arrives before a byte is complete aborts the transfer. The partial byte is not stored, and a repeated start begins a new address phase.
- R10: Data bytes written beyond the sixth are still acknowledged but ignored. A read that goes beyond byte 5 returns 0xFF. The byte pointers never wrap.
- R11: A pulse on SCL that lasts fewer than FILT_LEN system clocks is ignored and does not clock a bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe | output | 1 | High pulls SDA low (open-drain drive) |
| cfg_o | output | 48 | Six configuration bytes, byte k at bits 8k+7:8k |

## Verification
The bench builds the block with its default parameters. These are six bytes, device address 0x69, and a filter length of 4 clocks, with the inverted field on byte 1 bits 6:4. With a bit period of 100 system clocks, every SDA handoff happens well inside the SCL low phase. A 2-clock SCL glitch lies below the filter threshold. Six bytes are few enough that the bench can overrun both the write and the read pointers within one transfer each.

// File: rtl/cfg_i2c_slave.sv
module cfg_i2c_slave #(
  parameter int NUM_REGS = 6,
  parameter logic [6:0] DEV_ADDR = 7'h69,
  parameter int FILT_LEN = 4,
  parameter logic [NUM_REGS*8-1:0] DEFAULTS = 48'h06_00_00_FF_FF_FF,
  parameter int INV_BYTE = 1,
  parameter logic [7:0] INV_MASK = 8'h70
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe,
  output logic [NUM_REGS*8-1:0] cfg_o
);
  localparam int CW = $clog2(FILT_LEN + 1);
  localparam int WMAX = NUM_REGS + 2;
  localparam int RMAX = NUM_REGS + 1;
  localparam int WW = $clog2(WMAX + 1);
  localparam int PW = $clog2(RMAX + 1);
  localparam int IW = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  typedef enum logic [2:0] {S_IDLE, S_RX, S_ACK, S_TX, S_RACK} state_t;

  logic [1:0] ln_in, filt, filt_q;
  assign ln_in = {scl_i, sda_i};

  for (genvar g = 0; g < 2; g++) begin : g_filt
    logic s1, s2, f;
    logic [CW-1:0] cnt;
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        s1 <= 1'b1; s2 <= 1'b1; f <= 1'b1; cnt <= '0;
      end else begin
        s1 <= ln_in[g];
        s2 <= s1;
        if (s2 == f) cnt <= '0;
        else if (cnt == CW'(FILT_LEN - 1)) begin
          f <= s2; cnt <= '0;
        end else cnt <= cnt + 1'b1;
      end
    assign filt[g] = f;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) filt_q <= 2'b11;
    else filt_q <= filt;

  logic scl_f, sda_f, scl_q, sda_q, rise, fall, start, stop;
  assign {scl_f, sda_f} = filt;
  assign {scl_q, sda_q} = filt_q;
  assign rise  = scl_f & ~scl_q;
  assign fall  = ~scl_f & scl_q;
  assign start = scl_f & scl_q & sda_q & ~sda_f;
  assign stop  = scl_f & scl_q & ~sda_q & sda_f;

  state_t state;
  logic [3:0] bitcnt;
  logic [7:0] shreg, txsh, tx_next;
  logic first, rd, nack;
  logic [WW-1:0] wcnt;
  logic [PW-1:0] rptr;
  logic [7:0] regs [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_out
    assign cfg_o[8*g +: 8] = regs[g];
  end

  always_comb begin
    if (rptr == '0) tx_next = 8'(NUM_REGS);
    else if (rptr <= PW'(NUM_REGS))
      tx_next = regs[IW'(rptr - PW'(1))] ^ ((rptr == PW'(INV_BYTE + 1)) ? INV_MASK : 8'h00);
    else tx_next = 8'hFF;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state <= S_IDLE; bitcnt <= '0; shreg <= '0; txsh <= '0;
      first <= 1'b0; rd <= 1'b0; nack <= 1'b0; wcnt <= '0; rptr <= '0;
      sda_oe <= 1'b0;
      for (int k = 0; k < NUM_REGS; k++) regs[k] <= DEFAULTS[8*k +: 8];
    end else if (start) begin
      state <= S_RX; first <= 1'b1; bitcnt <= '0; sda_oe <= 1'b0;
      wcnt <= '0; rptr <= '0;
    end else if (stop) begin
      state <= S_IDLE; sda_oe <= 1'b0;
    end else begin
      case (state)
        S_RX: begin
          if (rise) begin
            shreg <= {shreg[6:0], sda_f};
            bitcnt <= bitcnt + 1'b1;
          end
          if (fall && bitcnt == 4'd8) begin
            bitcnt <= '0;
            if (first) begin
              first <= 1'b0;
              if (shreg[7:1] == DEV_ADDR) begin
                rd <= shreg[0]; sda_oe <= 1'b1; state <= S_ACK;
              end else begin
                sda_oe <= 1'b0; state <= S_IDLE;
              end
            end else begin
              sda_oe <= 1'b1; state <= S_ACK;
              if (wcnt >= WW'(2) && wcnt < WW'(WMAX)) regs[IW'(wcnt - WW'(2))] <= shreg;
              if (wcnt != WW'(WMAX)) wcnt <= wcnt + 1'b1;
            end
          end
        end
        S_ACK: if (fall) begin
          if (rd) begin
            txsh <= tx_next; sda_oe <= ~tx_next[7]; bitcnt <= '0; state <= S_TX;
            if (rptr != PW'(RMAX)) rptr <= rptr + 1'b1;
          end else begin
            sda_oe <= 1'b0; state <= S_RX;
          end
        end
        S_TX: begin
          if (rise) bitcnt <= bitcnt + 1'b1;
          if (fall) begin
            if (bitcnt == 4'd8) begin
              sda_oe <= 1'b0; bitcnt <= '0; state <= S_RACK;
            end else begin
              txsh <= {txsh[6:0], 1'b1}; sda_oe <= ~txsh[6];
            end
          end
        end
        S_RACK: begin
          if (rise) nack <= sda_f;
          if (fall) begin
            if (nack) begin
              sda_oe <= 1'b0; state <= S_IDLE;
            end else begin
              txsh <= tx_next; sda_oe <= ~tx_next[7]; bitcnt <= '0; state <= S_TX;
              if (rptr != PW'(RMAX)) rptr <= rptr + 1'b1;
            end
          end
        end
        default: sda_oe <= 1'b0;
      endcase
    end

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_IDLE |-> !sda_oe);
  p_store_on_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_o != $past(cfg_o) |-> sda_oe);
  p_sda_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    scl_f && scl_q |-> $stable(sda_oe));
  p_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> state == S_IDLE && !sda_oe);
  p_ptr_limit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wcnt <= WW'(WMAX) && rptr <= PW'(RMAX));
endmodule

// File: tb/cfg_i2c_slave_bench.sv
module cfg_i2c_slave_bench;
  localparam int Q = 25;
  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, sda_low = 1'b0;
  logic sda_oe, sda_line;
  logic [47:0] cfg;
  int vectors = 0, miscompares = 0;
  logic done = 1'b0;
  logic [7:0] mdl [6];

  always #2 clk = ~clk;
  assign sda_line = ~(sda_low | sda_oe);

  cfg_i2c_slave u_cfg_i2c_slave (.clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .sda_oe(sda_oe), .cfg_o(cfg));

  task automatic hold(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic bit_w(input logic b, input logic glitch);
    sda_low = ~b; hold(Q / 2);
    if (glitch) begin scl = 1'b1; hold(2); scl = 1'b0; end
    hold(Q / 2);
    scl = 1'b1; hold(2 * Q); scl = 1'b0; hold(Q);
  endtask

  task automatic bit_r(output logic b);
    sda_low = 1'b0; hold(Q); scl = 1'b1; hold(Q); b = sda_line; hold(Q);
    scl = 1'b0; hold(Q);
  endtask

  task automatic byte_w(input logic [7:0] d, input logic glitch, output logic ack);
    for (int i = 7; i >= 0; i--) bit_w(d[i], glitch);
    bit_r(ack);
  endtask

  task automatic byte_r(output logic [7:0] d, input logic nk);
    for (int i = 7; i >= 0; i--) bit_r(d[i]);
    bit_w(nk, 1'b0);
  endtask

  task automatic bus_start;
    sda_low = 1'b0; hold(Q); scl = 1'b1; hold(Q); sda_low = 1'b1; hold(Q);
    scl = 1'b0; hold(Q);
  endtask

  task automatic bus_stop;
    sda_low = 1'b1; hold(Q); scl = 1'b1; hold(Q); sda_low = 1'b0; hold(2 * Q);
  endtask

  task automatic chk_cfg(input string req);
    for (int k = 0; k < 6; k++) chk(req, 64'(cfg[8*k +: 8]), 64'(mdl[k]));
  endtask

  task automatic write_head(input logic glitch);
    logic a;
    bus_start;
    byte_w(8'hD2, glitch, a); chk("R1 write address ack", 64'(a), 64'd0);
    byte_w(8'h5A, glitch, a); chk("R2 command ack", 64'(a), 64'd0);
    byte_w(8'h02, glitch, a); chk("R2 count ack", 64'(a), 64'd0);
  endtask

  task automatic t_reset;
    chk("R8 reset value", 64'(cfg), 64'h06_00_00_FF_FF_FF);
    chk("R8 sda released", 64'(sda_oe), 64'd0);
    for (int k = 0; k < 6; k++) mdl[k] = 8'(64'h06_00_00_FF_FF_FF >> (8 * k));
  endtask

  task automatic t_bad_addr;
    logic a;
    bus_start; byte_w(8'hA4, 1'b0, a); chk("R1 foreign address nack", 64'(a), 64'd1);
    byte_w(8'h00, 1'b0, a); bus_stop;
    bus_start; byte_w(8'hD0, 1'b0, a); chk("R1 near address nack", 64'(a), 64'd1);
    byte_w(8'h00, 1'b0, a); byte_w(8'h00, 1'b0, a); byte_w(8'h00, 1'b0, a); bus_stop;
    chk_cfg("R1 no store after nack");
  endtask

  task automatic t_write_all;
    logic a;
    logic [7:0] d [6] = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66};
    write_head(1'b0);
    for (int k = 0; k < 6; k++) begin
      byte_w(d[k], 1'b0, a); chk("R4 data ack", 64'(a), 64'd0); mdl[k] = d[k];
    end
    bus_stop;
    chk_cfg("R3 in-order store");
    chk("R2 command not stored", 64'(cfg[7:0] == 8'h5A), 64'd0);
    chk("R7 stored as written", 64'(cfg[15:8]), 64'h22);
  endtask

  task automatic t_read_all;
    logic a;
    logic [7:0] v;
    bus_start; byte_w(8'hD3, 1'b0, a); chk("R1 read address ack", 64'(a), 64'd0);
    byte_r(v, 1'b0); chk("R6 count byte", 64'(v), 64'd6);
    for (int k = 0; k < 6; k++) begin
      byte_r(v, k == 5);
      if (k == 1) chk("R7 inverted field", 64'(v), 64'(mdl[1] ^ 8'h70));
      else chk("R6 read byte", 64'(v), 64'(mdl[k]));
    end
    bus_stop;
    bus_start; byte_w(8'hD3, 1'b0, a);
    byte_r(v, 1'b0); chk("R6 count again", 64'(v), 64'd6);
    byte_r(v, 1'b1); chk("R6 byte 0 again", 64'(v), 64'(mdl[0]));
    bus_stop;
  endtask

  task automatic t_partial;
    logic a;
    write_head(1'b0);
    byte_w(8'hA5, 1'b0, a); byte_w(8'h3C, 1'b0, a); bus_stop;
    mdl[0] = 8'hA5; mdl[1] = 8'h3C;
    chk_cfg("R5 partial write");
  endtask

  task automatic t_abort;
    logic a;
    write_head(1'b0);
    for (int i = 0; i < 4; i++) bit_w(1'b1, 1'b0);
    bus_stop;
    chk_cfg("R9 stop mid-byte");
    write_head(1'b0);
    for (int i = 0; i < 3; i++) bit_w(1'b0, 1'b0);
    write_head(1'b0);
    byte_w(8'h77, 1'b0, a); bus_stop;
    mdl[0] = 8'h77;
    chk_cfg("R9 repeated start mid-byte");
  endtask

  task automatic t_overflow;
    logic a;
    logic [7:0] v;
    write_head(1'b0);
    for (int k = 0; k < 8; k++) begin
      byte_w(8'h80 + 8'(k), 1'b0, a); chk("R10 extra byte ack", 64'(a), 64'd0);
      if (k < 6) mdl[k] = 8'h80 + 8'(k);
    end
    bus_stop;
    chk_cfg("R10 no wrap on write");
    bus_start; byte_w(8'hD3, 1'b0, a);
    byte_r(v, 1'b0);
    for (int k = 0; k < 6; k++) byte_r(v, 1'b0);
    byte_r(v, 1'b0); chk("R10 read past end", 64'(v), 64'hFF);
    byte_r(v, 1'b1); chk("R10 read past end 2", 64'(v), 64'hFF);
    bus_stop;
  endtask

  task automatic t_glitch;
    logic a;
    write_head(1'b1);
    byte_w(8'hC3, 1'b1, a); chk("R11 ack with glitches", 64'(a), 64'd0);
    byte_w(8'h5E, 1'b1, a);
    bus_stop;
    mdl[0] = 8'hC3; mdl[1] = 8'h5E;
    chk_cfg("R11 glitch ignored");
  endtask

  initial begin
    hold(5); rst_n = 1'b1; hold(5);
    t_reset;
    t_bad_addr;
    t_write_all;
    t_read_all;
    t_partial;
    t_abort;
    t_overflow;
    t_glitch;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog R4 act=running exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule